// File: doc/BRIEF.md
# Bimodal Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a table of 2-bit saturating counters. Each counter is selected by a slice of the branch address. A fetch stage presents a program counter on the lookup port and gets back a taken/not-taken guess in the same cycle. When the branch resolves later, the execute stage presents that branch's address and its real direction on the update port. The selected counter then moves one step toward that direction.

The counter has two strong states and two weak states. These give hysteresis: a branch that is taken almost always, such as a loop back-edge, is mispredicted only once at the loop exit. It is not mispredicted again when the loop is entered next time.

Every counter starts weakly taken after reset, because most branches are taken. The table has no tags. Branches whose index bits are equal share one counter.

Top module: `bimodal_predictor`

## Requirements
- R1: Each counter holds one of four 2-bit codes: 2'b00 strongly not-taken, 2'b01 weakly not-taken, 2'b10 weakly taken, 2'b11 strongly taken. The guess is taken exactly when bit 1 of the addressed counter is 1.
- R2: While reset is low, every counter is loaded with 2'b10. After reset, every lookup guesses taken, and a single not-taken update makes that entry guess not-taken.
- R3: A valid update with outcome taken adds one to the addressed counter. At 2'b11 the counter stays at 2'b11 and does not wrap.
- R4: A valid update with outcome not-taken subtracts one from the addressed counter. At 2'b00 the counter stays at 2'b00 and does not wrap.
- R5: Starting from 2'b11, the first not-taken update leaves the guess at taken. Only the second consecutive not-taken update turns the guess to not-taken.
- R6: The entry index is PC[IDX_W+1:2]. PC bits 1:0 and the PC bits above IDX_W+1 have no effect on which entry is used. With IDX_W = 12, PC 0x00401A3C selects entry 0x68F, the same entry as PC 0x00001A3C.
- R7: Two addresses with equal index bits share one counter, and there is no tag comparison. An update through one address changes the guess returned for the other.
- R8: If a lookup and an update select the same entry in one cycle, the lookup returns the guess from the counter value before the update. The new value is seen from the next cycle on.
- R9: The table changes only in cycles where upd_valid is high. In other cycles, upd_pc and upd_taken have no effect.
- R10: The guess is a combinational function of lkp_pc and the stored counters, so it is valid in the same cycle the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counters update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads every counter with 2'b10 |
| lkp_pc | input | PC_W | Fetch address to predict |
| lkp_taken | output | 1 | Guess for lkp_pc: 1 = taken, 0 = not-taken |
| upd_valid | input | 1 | High when a resolved branch is presented on the update port |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Actual direction of the resolved branch: 1 = taken |

## Verification
The bench builds the block with its default parameters: a 32-bit PC and a 12-bit index, which gives 4096 entries. With these values, the address 0x00401A3C and its aliases can be checked directly against entry 0x68F. PCs that differ only above bit 13 or only in bits 1:0 must land on the same counter, and the bench checks this. The bench also checks that the neighbouring entry 0x68E is not touched. The same configuration exercises saturation at both ends, the two-step reversal out of the strong states, and updates sent with the valid strobe low. It also covers a lookup and an update that hit the same entry in one cycle.

// File: rtl/bimodal_predictor.sv
module bimodal_predictor #(
  parameter int         PC_W       = 32,
  parameter int         IDX_W      = 12,
  parameter logic [1:0] INIT_STATE = 2'b10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lkp_pc,
  output logic            lkp_taken,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken
);

  localparam int         DEPTH   = 1 << IDX_W;
  localparam logic [1:0] CTR_MAX = 2'b11;
  localparam logic [1:0] CTR_MIN = 2'b00;

  logic [1:0]       ctr_q [DEPTH];
  logic [IDX_W-1:0] lkp_idx;
  logic [IDX_W-1:0] upd_idx;
  logic [1:0]       upd_cur;
  logic [1:0]       upd_nxt;

  assign lkp_idx = lkp_pc[IDX_W+1:2];
  assign upd_idx = upd_pc[IDX_W+1:2];
  assign upd_cur = ctr_q[upd_idx];

  wire unused_pc_bits = ^{lkp_pc[PC_W-1:IDX_W+2], lkp_pc[1:0],
                          upd_pc[PC_W-1:IDX_W+2], upd_pc[1:0]};

  always_comb begin
    if (upd_taken)
      upd_nxt = (upd_cur == CTR_MAX) ? upd_cur : upd_cur + 2'd1;
    else
      upd_nxt = (upd_cur == CTR_MIN) ? upd_cur : upd_cur - 2'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= INIT_STATE;
    end else if (upd_valid) begin
      ctr_q[upd_idx] <= upd_nxt;
    end
  end

  assign lkp_taken = ctr_q[lkp_idx][1];

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_cur != CTR_MAX)
      |=> ctr_q[$past(upd_idx)] == $past(upd_cur) + 2'd1);

  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_cur == CTR_MAX)
      |=> ctr_q[$past(upd_idx)] == CTR_MAX);

  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_cur != CTR_MIN)
      |=> ctr_q[$past(upd_idx)] == $past(upd_cur) - 2'd1);

  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_cur == CTR_MIN)
      |=> ctr_q[$past(upd_idx)] == CTR_MIN);

  assert_hysteresis_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && upd_cur == CTR_MAX)
      |=> ctr_q[$past(upd_idx)][1]);

  assert_no_upd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_valid |=> ctr_q[$past(upd_idx)] == $past(upd_cur));

endmodule

// File: tb/bimodal_predictor_tb.sv
module bimodal_predictor_tb;

  localparam int PC_W  = 32;
  localparam int IDX_W = 12;

  typedef struct {
    logic  exp;
    string req;
  } item_t;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [PC_W-1:0] lkp_pc = '0;
  logic            lkp_taken;
  logic            upd_valid = 1'b0;
  logic [PC_W-1:0] upd_pc = '0;
  logic            upd_taken = 1'b0;

  item_t      sb_q[$];
  logic [1:0] mdl [int];
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #4 clk = ~clk;

  bimodal_predictor #(.PC_W(PC_W), .IDX_W(IDX_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .lkp_pc(lkp_pc), .lkp_taken(lkp_taken),
    .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

  function automatic int idx_of(input logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic logic [1:0] mdl_get(input logic [PC_W-1:0] pc);
    return mdl.exists(idx_of(pc)) ? mdl[idx_of(pc)] : 2'b10;
  endfunction

  task automatic step(input logic [PC_W-1:0] lpc, input logic uv,
                      input logic [PC_W-1:0] upc, input logic ut, input string req);
    item_t it;
    logic [1:0] c;
    @(negedge clk);
    lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    it.exp = mdl_get(lpc)[1];
    it.req = req;
    sb_q.push_back(it);
    if (uv) begin
      c = mdl_get(upc);
      if (ut) c = (c == 2'b11) ? c : c + 2'd1;
      else    c = (c == 2'b00) ? c : c - 2'd1;
      mdl[idx_of(upc)] = c;
    end
  endtask

  task automatic look(input logic [PC_W-1:0] lpc, input string req);
    step(lpc, 1'b0, 32'h0, 1'b0, req);
  endtask

  task automatic train(input logic [PC_W-1:0] pc, input logic ut, input string req);
    step(pc, 1'b1, pc, ut, req);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        n_cmp++;
        if (lkp_taken !== it.exp) begin
          n_bad++;
          $display("FAIL %s: pc=%h actual=%b expected=%b", it.req, lkp_pc, lkp_taken, it.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R2 reset state: weakly taken everywhere
    look(32'h0000_0000, "R2");
    look(32'hFFFF_FFFC, "R2");
    look(32'h0040_1A3C, "R2");
    // R8 same-cycle lookup sees old value; R2 one NT from 10 -> 01
    step(32'h0040_1A3C, 1'b1, 32'h0040_1A3C, 1'b0, "R8");
    look(32'h0040_1A3C, "R2 R10");
    // R6 index 0x68F, alignment and high bits ignored
    look(32'h0000_1A3C, "R6");
    look(32'h0040_1A3F, "R6");
    look(32'h0000_1A38, "R6 neighbour");
    // R7 aliasing: high bits differ, shared counter
    train(32'h1234_5A3C, 1'b1, "R7");
    look(32'h0040_1A3C, "R7");
    // R3 saturation high then R5 hysteresis
    for (int i = 0; i < 5; i++) train(32'h0000_0100, 1'b1, "R3");
    train(32'h0000_0100, 1'b0, "R5");
    look(32'h0000_0100, "R5");
    train(32'h0000_0100, 1'b0, "R5");
    look(32'h0000_0100, "R5 R1");
    // R4 saturation low
    for (int i = 0; i < 5; i++) train(32'h0000_0200, 1'b0, "R4");
    train(32'h0000_0200, 1'b1, "R4");
    look(32'h0000_0200, "R4 R1");
    train(32'h0000_0200, 1'b1, "R4");
    look(32'h0000_0200, "R4 R1");
    // R9 updates without valid strobe are ignored
    for (int i = 0; i < 4; i++) step(32'h0000_0300, 1'b0, 32'h0000_0300, 1'b0, "R9");
    look(32'h0000_0300, "R9");
    for (int i = 0; i < 4; i++) step(32'h0000_0200, 1'b0, 32'h0000_0200, 1'b0, "R9");
    look(32'h0000_0200, "R9");
    // R1 alternating pattern
    for (int i = 0; i < 6; i++) train(32'h0000_0400, i[0], "R1");
    look(32'h0000_0400, "R1");
    repeat (3) @(negedge clk);
    wait (sb_q.size() == 0);
    #3;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule